// File: doc/BRIEF.md
# Clock Source Switch Sequencer

This block moves a core clock from an always-running internal RC oscillator to a primary oscillator path. That path is either the raw primary clock or its PLL-multiplied version. When the source-select input asks for the primary source, the block enables the primary oscillator and counts its start-up periods on the primary clock itself. When the PLL is requested, it then waits a lock interval counted on the low-frequency internal clock. Only after these delays does it hand the core over through a glitch-free two-input clock gate. The core keeps running from the internal clock, with no gap, until the handover.

Two status flags report which source drives the core: "primary ready" and "internal stable". Exactly one of them is high at any time, and both change in the same cycle when a handover completes. Selecting the internal source reverses the handover. A change of the request while a switch is still pending either abandons the switch or restarts the start-up count. A PLL change made while the core already runs on the primary path waits for the next switch. The low-frequency oscillator enable stays high whenever the watchdog or the clock-failure monitor is enabled.

Top module: `clksw_seq`

## Requirements
- R1: From reset, and for as long as a switch to the primary source is pending, the core clock follows the internal clock edge for edge; after reset, int_stable=1, pri_ready=0, pri_osc_en=0 and lf_osc_en=0 with both enables low.
- R2: src_sel encoding: bit 1 low (00 or 01) requests the primary source, bit 1 high requests the internal source. During a pending request pri_osc_en is high, and pri_ready does not rise before OST_CYCLES primary periods have elapsed since the request.
- R3: With pll_req high at the request, pri_ready does not rise before OST_CYCLES primary periods plus LOCK_CYCLES low-frequency periods, and the core then follows the PLL clock.
- R4: Once the minimum delay of R2/R3 has elapsed, the handover and the flag update complete within 100 internal clock periods.
- R5: On completion pri_ready rises and int_stable falls in the same cycle, with the primary path gate open and the internal gate closed; the core then follows the selected primary path; exactly one of the two flags is high at all times.
- R6: Selecting the internal source while running on the primary returns the core to the internal clock, sets int_stable, clears pri_ready and drops pri_osc_en.
- R7: lf_osc_en is high whenever wdog_en or clkmon_en has been high for 4 internal clock periods; with both low and no PLL lock pending it is low.
- R8: If the internal source is selected again while a switch is pending, int_stable never falls and pri_ready stays 0.
- R9: The two clock gates are never open together, and no core clock pulse is shorter than half the period of the fastest source.
- R10: A change of src_sel or pll_req while a switch is pending restarts the sequence, so the minimum delay of R2/R3 counts from the latest change.
- R11: A change of pll_req while the core runs on the primary path has no effect on the core clock or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal RC oscillator clock; also clocks the control logic |
| clk_pri | input | 1 | Primary oscillator clock |
| clk_pll | input | 1 | PLL output clock derived from the primary |
| clk_lf | input | 1 | Low-frequency internal clock, used for the lock timer |
| rst | input | 1 | Synchronous active-high reset, held over several periods of every clock |
| src_sel | input | 2 | Source select: bit 1 high = internal, else primary |
| pll_req | input | 1 | Use the PLL path when switching to the primary |
| wdog_en | input | 1 | Watchdog enabled (keeps the low-frequency oscillator on) |
| clkmon_en | input | 1 | Clock-failure monitor enabled (keeps the low-frequency oscillator on) |
| clk_core | output | 1 | Glitch-free selected core clock |
| pri_ready | output | 1 | Primary start-up complete, core runs on the primary path |
| int_stable | output | 1 | Core runs on the stable internal clock |
| pri_osc_en | output | 1 | Primary oscillator enable |
| lf_osc_en | output | 1 | Low-frequency oscillator enable |

## Verification
The hardest case to reach is a restart in the middle of a pending switch. The request must change after the start-up count is well under way but before it ends. The start-up and lock delays must then be shown to count again from that change, and not from the first request. The stimulus requests the primary source without the PLL and waits about half the start-up count. It then raises pll_req and checks that the ready flag rises no earlier than a full start-up count plus a full lock interval after that change. In a separate pass, the internal source is reselected partway through a start-up count. The bench then holds for longer than the count would have taken, to show that the internal-stable flag never drops.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;

  typedef enum logic [2:0] {
    ST_INT  = 3'd0,  // core on internal clock, primary off
    ST_ARM  = 3'd1,  // primary enabled, waiting for timers to clear
    ST_OST  = 3'd2,  // start-up count running
    ST_LOCK = 3'd3,  // PLL lock delay running
    ST_SWAP = 3'd4,  // gate handover to primary path
    ST_PRI  = 3'd5,  // core on primary path
    ST_BACK = 3'd6   // gate handover back to internal
  } sw_state_t;

endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/1ps
module clksw_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/clksw_cyc_timer.sv
`timescale 1ns/1ps
module clksw_cyc_timer #(
  parameter int LIMIT       = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done,
  output logic ack
);

  localparam int CW = $clog2(LIMIT + 1);

  logic          run_s;
  logic [CW-1:0] cnt;

  clksw_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_run_sync (
    .clk(clk), .rst(rst), .d(run), .q(run_s)
  );

  always_ff @(posedge clk) begin
    if (rst || !run_s) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(LIMIT - 1)) done <= 1'b1;
    end
  end

  // ack stays high until both the run level and done have cleared
  always_ff @(posedge clk) begin
    if (rst) ack <= 1'b0;
    else     ack <= run_s | done;
  end

endmodule

// File: rtl/clksw_gfmux.sv
`timescale 1ns/1ps
module clksw_gfmux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst,
  input  logic sel_b,
  output logic clk_o,
  output logic en_a,
  output logic en_b
);

  logic a_req_s, b_req_s;

  clksw_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_a_sync (
    .clk(clk_a), .rst(rst), .d(~sel_b & ~en_b), .q(a_req_s)
  );

  clksw_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_b_sync (
    .clk(clk_b), .rst(rst), .d(sel_b & ~en_a), .q(b_req_s)
  );

  // gates change only while their own clock is low
  always_ff @(negedge clk_a) begin
    if (rst) en_a <= 1'b1;
    else     en_a <= a_req_s;
  end

  always_ff @(negedge clk_b) begin
    if (rst) en_b <= 1'b0;
    else     en_b <= b_req_s;
  end

  assign clk_o = (clk_a & en_a) | (clk_b & en_b);

endmodule

// File: rtl/clksw_ctrl.sv
`timescale 1ns/1ps
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter bit PLL_SUPPORT = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel_s,
  input  logic       pll_s,
  input  logic       wdog_s,
  input  logic       mon_s,
  input  logic       ost_done_s,
  input  logic       ost_ack_s,
  input  logic       lock_done_s,
  input  logic       lock_ack_s,
  input  logic       pri_act_s,
  input  logic       int_act_s,
  output logic       ost_run,
  output logic       lock_run,
  output logic       mux_sel_pri,
  output logic       use_pll,
  output logic       pri_ready,
  output logic       int_stable,
  output logic       pri_osc_en,
  output logic       lf_osc_en
);

  sw_state_t  state;
  logic [1:0] sel_q;
  logic       pll_q;
  logic       want_pri, pll_eff, chg, lock_window;

  assign want_pri    = ~sel_s[1];
  assign pll_eff     = pll_s & PLL_SUPPORT;
  assign chg         = (sel_s != sel_q) || (pll_s != pll_q);
  assign lock_window = use_pll &&
                       ((state == ST_ARM) || (state == ST_OST) || (state == ST_LOCK));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_INT;
      sel_q       <= 2'b10;
      pll_q       <= 1'b0;
      ost_run     <= 1'b0;
      lock_run    <= 1'b0;
      mux_sel_pri <= 1'b0;
      use_pll     <= 1'b0;
      pri_ready   <= 1'b0;
      int_stable  <= 1'b1;
      pri_osc_en  <= 1'b0;
      lf_osc_en   <= 1'b0;
    end else begin
      sel_q     <= sel_s;
      pll_q     <= pll_s;
      lf_osc_en <= wdog_s | mon_s | lock_window;
      case (state)
        ST_INT: begin
          if (want_pri) begin
            state      <= ST_ARM;
            use_pll    <= pll_eff;
            pri_osc_en <= 1'b1;
          end
        end
        ST_ARM: begin
          ost_run  <= 1'b0;
          lock_run <= 1'b0;
          use_pll  <= pll_eff;
          if (!want_pri) begin
            state      <= ST_INT;
            pri_osc_en <= 1'b0;
          end else if (!ost_ack_s && !lock_ack_s) begin
            state   <= ST_OST;
            ost_run <= 1'b1;
          end
        end
        ST_OST: begin
          if (!want_pri) begin
            state      <= ST_INT;
            ost_run    <= 1'b0;
            pri_osc_en <= 1'b0;
          end else if (chg) begin
            state   <= ST_ARM;
            ost_run <= 1'b0;
          end else if (ost_done_s) begin
            if (use_pll) begin
              state    <= ST_LOCK;
              lock_run <= 1'b1;
            end else begin
              state       <= ST_SWAP;
              mux_sel_pri <= 1'b1;
            end
          end
        end
        ST_LOCK: begin
          if (!want_pri) begin
            state      <= ST_INT;
            ost_run    <= 1'b0;
            lock_run   <= 1'b0;
            pri_osc_en <= 1'b0;
          end else if (chg) begin
            state    <= ST_ARM;
            ost_run  <= 1'b0;
            lock_run <= 1'b0;
          end else if (lock_done_s) begin
            state       <= ST_SWAP;
            mux_sel_pri <= 1'b1;
          end
        end
        ST_SWAP: begin
          if (pri_act_s && !int_act_s) begin
            state      <= ST_PRI;
            pri_ready  <= 1'b1;
            int_stable <= 1'b0;
          end
        end
        ST_PRI: begin
          if (!want_pri) begin
            state       <= ST_BACK;
            mux_sel_pri <= 1'b0;
          end
        end
        ST_BACK: begin
          if (int_act_s && !pri_act_s) begin
            state      <= ST_INT;
            pri_ready  <= 1'b0;
            int_stable <= 1'b1;
            pri_osc_en <= 1'b0;
            ost_run    <= 1'b0;
            lock_run   <= 1'b0;
          end
        end
        default: state <= ST_INT;
      endcase
    end
  end

endmodule

// File: rtl/clksw_seq.sv
`timescale 1ns/1ps
module clksw_seq #(
  parameter int OST_CYCLES  = 1024,
  parameter int LOCK_CYCLES = 64,
  parameter bit PLL_SUPPORT = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_int,
  input  logic       clk_pri,
  input  logic       clk_pll,
  input  logic       clk_lf,
  input  logic       rst,
  input  logic [1:0] src_sel,
  input  logic       pll_req,
  input  logic       wdog_en,
  input  logic       clkmon_en,
  output logic       clk_core,
  output logic       pri_ready,
  output logic       int_stable,
  output logic       pri_osc_en,
  output logic       lf_osc_en
);

  localparam int IN_W = 5;
  localparam int FB_W = 6;

  logic [IN_W-1:0] in_s;
  logic [FB_W-1:0] fb_raw, fb_s;
  logic ost_run, lock_run, ost_done, ost_ack, lock_done, lock_ack;
  logic mux_sel_pri, use_pll, clk_path;
  logic gate_int, gate_pri;

  clksw_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(5'b10000)) u_in_sync (
    .clk(clk_int), .rst(rst),
    .d({src_sel, pll_req, wdog_en, clkmon_en}), .q(in_s)
  );

  clksw_cyc_timer #(.LIMIT(OST_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_ost (
    .clk(clk_pri), .rst(rst), .run(ost_run), .done(ost_done), .ack(ost_ack)
  );

  generate
    if (PLL_SUPPORT) begin : g_lock
      clksw_cyc_timer #(.LIMIT(LOCK_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_lock (
        .clk(clk_lf), .rst(rst), .run(lock_run), .done(lock_done), .ack(lock_ack)
      );
      // path choice only moves while the primary gate is closed
      assign clk_path = use_pll ? clk_pll : clk_pri;
    end else begin : g_nolock
      assign lock_done = 1'b1;
      assign lock_ack  = 1'b0;
      assign clk_path  = clk_pri;
    end
  endgenerate

  assign fb_raw = {ost_done, ost_ack, lock_done, lock_ack, gate_pri, gate_int};

  clksw_sync #(.W(FB_W), .STAGES(SYNC_STAGES), .RST_VAL(6'b000000)) u_fb_sync (
    .clk(clk_int), .rst(rst), .d(fb_raw), .q(fb_s)
  );

  clksw_gfmux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .clk_a(clk_int), .clk_b(clk_path), .rst(rst), .sel_b(mux_sel_pri),
    .clk_o(clk_core), .en_a(gate_int), .en_b(gate_pri)
  );

  clksw_ctrl #(.PLL_SUPPORT(PLL_SUPPORT)) u_ctrl (
    .clk(clk_int), .rst(rst),
    .sel_s(in_s[4:3]), .pll_s(in_s[2]), .wdog_s(in_s[1]), .mon_s(in_s[0]),
    .ost_done_s(fb_s[5]), .ost_ack_s(fb_s[4]),
    .lock_done_s(fb_s[3]), .lock_ack_s(fb_s[2]),
    .pri_act_s(fb_s[1]), .int_act_s(fb_s[0]),
    .ost_run(ost_run), .lock_run(lock_run), .mux_sel_pri(mux_sel_pri),
    .use_pll(use_pll), .pri_ready(pri_ready), .int_stable(int_stable),
    .pri_osc_en(pri_osc_en), .lf_osc_en(lf_osc_en)
  );

endmodule

// File: rtl/clksw_seq_chk.sv
`timescale 1ns/1ps
module clksw_seq_chk (
  input logic clk_int,
  input logic rst,
  input logic gate_int,
  input logic gate_pri,
  input logic pri_ready,
  input logic int_stable,
  input logic pri_osc_en,
  input logic lf_osc_en,
  input logic wdog_en,
  input logic clkmon_en
);

  logic [2:0] keep_n;

  always_ff @(posedge clk_int) begin
    if (rst || !(wdog_en || clkmon_en)) keep_n <= '0;
    else if (keep_n != 3'd7)            keep_n <= keep_n + 1'b1;
  end

  p_gates_excl_r9: assert property (@(posedge clk_int) disable iff (rst)
    !(gate_int && gate_pri));

  p_flags_one_r5: assert property (@(posedge clk_int) disable iff (rst)
    $countones({pri_ready, int_stable}) == 1);

  p_ready_gate_r5: assert property (@(posedge clk_int) disable iff (rst)
    $rose(pri_ready) |-> (gate_pri && !gate_int));

  p_ready_osc_r2: assert property (@(posedge clk_int) disable iff (rst)
    pri_ready |-> pri_osc_en);

  p_idle_int_r6: assert property (@(posedge clk_int) disable iff (rst)
    !pri_osc_en |-> (int_stable && gate_int));

  p_lf_keep_r7: assert property (@(posedge clk_int) disable iff (rst)
    (keep_n >= 3'd4) |-> lf_osc_en);

endmodule

bind clksw_seq clksw_seq_chk u_chk (
  .clk_int(clk_int), .rst(rst), .gate_int(gate_int), .gate_pri(gate_pri),
  .pri_ready(pri_ready), .int_stable(int_stable), .pri_osc_en(pri_osc_en),
  .lf_osc_en(lf_osc_en), .wdog_en(wdog_en), .clkmon_en(clkmon_en)
);

// File: tb/clksw_seq_bench.sv
`timescale 1ns/1ps
module clksw_seq_bench;

  localparam int  OST  = 1024;
  localparam int  LOCK = 64;
  localparam real TPRI = 30.0;
  localparam real TLF  = 200.0;
  localparam real SLACK = 2000.0;  // 100 internal periods

  logic clk_int = 0, clk_pri = 0, clk_pll = 0, clk_lf = 0;
  logic rst = 1;
  logic [1:0] src_sel = 2'b10;
  logic pll_req = 0, wdog_en = 0, clkmon_en = 0;
  logic clk_core, pri_ready, int_stable, pri_osc_en, lf_osc_en;

  int total = 0, bad = 0;
  longint n_int = 0, n_pri = 0, n_pll = 0, n_core = 0;
  bit model_on = 0, abort_watch = 0;
  int keep_n = 0, want_n = 0;
  realtime t_edge = 0, min_pulse = 1.0e9;

  always #10   clk_int = ~clk_int;
  always #15   clk_pri = ~clk_pri;
  always #3.75 clk_pll = ~clk_pll;
  always #100  clk_lf  = ~clk_lf;

  clksw_seq #(.OST_CYCLES(OST), .LOCK_CYCLES(LOCK)) u_clksw_seq (
    .clk_int(clk_int), .clk_pri(clk_pri), .clk_pll(clk_pll), .clk_lf(clk_lf),
    .rst(rst), .src_sel(src_sel), .pll_req(pll_req), .wdog_en(wdog_en),
    .clkmon_en(clkmon_en), .clk_core(clk_core), .pri_ready(pri_ready),
    .int_stable(int_stable), .pri_osc_en(pri_osc_en), .lf_osc_en(lf_osc_en)
  );

  always @(posedge clk_int)  n_int++;
  always @(posedge clk_pri)  n_pri++;
  always @(posedge clk_pll)  n_pll++;
  always @(posedge clk_core) n_core++;

  always @(clk_core) begin
    if (model_on) begin
      if ($realtime - t_edge < min_pulse) min_pulse = $realtime - t_edge;
    end
    t_edge = $realtime;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // per-clock reference rules
  always @(negedge clk_int) begin
    if (model_on) begin
      chk((pri_ready + int_stable) == 1, "R5", "one flag", {pri_ready, int_stable}, 1);
      keep_n = (wdog_en || clkmon_en) ? keep_n + 1 : 0;
      if (keep_n >= 5) chk(lf_osc_en == 1, "R7", "lf enable held", lf_osc_en, 1);
      want_n = !src_sel[1] ? want_n + 1 : 0;
      if (want_n >= 5) chk(pri_osc_en == 1, "R2", "primary enable", pri_osc_en, 1);
      if (abort_watch) chk(int_stable && !pri_ready, "R8", "abort flags",
                           {pri_ready, int_stable}, 1);
    end
  end

  task automatic drive(input logic [1:0] s, input logic p);
    @(posedge clk_int); #2;
    src_sel = s;
    pll_req = p;
  endtask

  task automatic wait_flag(input bit want_ready, input realtime limit);
    while (((want_ready ? pri_ready : int_stable) != 1'b1) && ($realtime < limit))
      @(negedge clk_int);
  endtask

  // which: 0 internal, 1 primary, 2 PLL
  task automatic measure(input int which, input string req);
    longint c0, s0, dc, ds;
    @(negedge clk_int);
    c0 = n_core;
    s0 = (which == 0) ? n_int : (which == 1) ? n_pri : n_pll;
    #1200;
    dc = n_core - c0;
    ds = ((which == 0) ? n_int : (which == 1) ? n_pri : n_pll) - s0;
    chk((dc - ds <= 1) && (ds - dc <= 1), req, "core edges vs source", dc, ds);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_int);
    chk(0, "WD", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    realtime t0, t1, el, lo;
    repeat (30) @(posedge clk_int);
    #2 rst = 0;
    repeat (4) @(negedge clk_int);
    model_on = 1;
    // R1 reset state
    chk(int_stable == 1, "R1", "reset int_stable", int_stable, 1);
    chk(pri_ready == 0, "R1", "reset pri_ready", pri_ready, 0);
    chk(pri_osc_en == 0, "R1", "reset pri_osc_en", pri_osc_en, 0);
    chk(lf_osc_en == 0, "R1", "reset lf_osc_en", lf_osc_en, 0);
    measure(0, "R1");

    // plain switch to primary, no PLL
    drive(2'b00, 0); t0 = $realtime;
    repeat (300) @(negedge clk_int);
    chk(pri_ready == 0, "R2", "early ready", pri_ready, 0);
    measure(0, "R1");
    lo = OST * TPRI;
    wait_flag(1, t0 + lo + SLACK);
    el = $realtime - t0;
    chk(el >= lo, "R2", "start-up delay ns", longint'(el), longint'(lo));
    chk(el <= lo + SLACK, "R4", "handover late ns", longint'(el), longint'(lo + SLACK));
    chk(int_stable == 0, "R5", "int_stable cleared", int_stable, 0);
    measure(1, "R5");

    // back to internal
    drive(2'b10, 0); t0 = $realtime;
    wait_flag(0, t0 + SLACK);
    chk(pri_ready == 0 && int_stable == 1, "R6", "flags on return",
        {pri_ready, int_stable}, 1);
    repeat (5) @(negedge clk_int);
    chk(pri_osc_en == 0, "R6", "primary off", pri_osc_en, 0);
    measure(0, "R6");

    // abort while pending
    abort_watch = 1;
    drive(2'b00, 0);
    repeat (500) @(negedge clk_int);
    measure(0, "R1");
    drive(2'b11, 0);
    repeat (2000) @(negedge clk_int);
    abort_watch = 0;
    chk(pri_ready == 0, "R8", "no ready after abort", pri_ready, 0);
    chk(pri_osc_en == 0, "R8", "primary off after abort", pri_osc_en, 0);
    measure(0, "R8");

    // restart with PLL request mid-count, watchdog on
    @(posedge clk_int); #2 wdog_en = 1;
    drive(2'b01, 0);
    repeat (800) @(negedge clk_int);
    drive(2'b01, 1); t1 = $realtime;
    lo = OST * TPRI + LOCK * TLF;
    wait_flag(1, t1 + lo + SLACK);
    el = $realtime - t1;
    chk(el >= lo, "R10", "restart delay ns", longint'(el), longint'(lo));
    chk(el >= lo, "R3", "lock delay ns", longint'(el), longint'(lo));
    chk(el <= lo + SLACK, "R4", "pll handover late ns", longint'(el), longint'(lo + SLACK));
    measure(2, "R3");

    // PLL change ignored while on primary
    drive(2'b01, 0);
    repeat (300) @(negedge clk_int);
    chk(pri_ready == 1, "R11", "still ready", pri_ready, 1);
    measure(2, "R11");
    chk(lf_osc_en == 1, "R7", "lf on with watchdog", lf_osc_en, 1);

    // return, then low-frequency enable rules
    drive(2'b10, 0); t0 = $realtime;
    wait_flag(0, t0 + SLACK);
    chk(int_stable == 1, "R6", "int_stable after pll return", int_stable, 1);
    measure(0, "R6");
    @(posedge clk_int); #2 wdog_en = 0;
    repeat (10) @(negedge clk_int);
    chk(lf_osc_en == 0, "R7", "lf off", lf_osc_en, 0);
    @(posedge clk_int); #2 clkmon_en = 1;
    repeat (10) @(negedge clk_int);
    chk(lf_osc_en == 1, "R7", "lf on with monitor", lf_osc_en, 1);

    chk(min_pulse >= 3.7, "R9", "min core pulse ps",
        longint'(min_pulse * 1000.0), 3700);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule